// File: doc/BRIEF.md
# DMA Address Remapping Walker

This block turns the address carried by a device's DMA request into a host physical address. It first finds the device. The requester's bus number selects an entry in a root table. That entry points to a per-bus context table. The device and function numbers then select the context entry, which names the top of that device's own translation tree. The walker then descends four page-table levels of 512 entries each, with 4 KB pages, and joins the leaf frame with the untranslated page offset.

All table entries are fetched through a narrow memory read port that allows one read in flight. A walk either ends with a translated address or stops early with a 3-bit fault code. A walk that stops on a fault performs no further reads. The walker accepts one request at a time and keeps its ready output low for the whole walk, so it can sit behind any arbiter that holds a request until it is accepted.

Top module: `dma_remap_walker`

## Requirements
- R1: The requester ID is split as bus = bits 15:8, device = bits 7:3 and function = bits 2:0. The first read of a walk is at rootBase*4096 + bus*8.
- R2: The second read is the context entry at B*4096 + devfn*8. B is the base field of the root entry and devfn is requester-ID bits 7:0.
- R3: The next four reads follow in a fixed order, using the index address bits 47:39, then 38:30, then 29:21, then 20:12. Each read is at B*4096 + index*8, where B is the base field of the previous entry.
- R4: Every 64-bit entry is decoded as follows: bit 0 = present, bit 1 = read allowed, bit 2 = write allowed, bits 51:12 = next base (frame number). All other bits are ignored. The read and write bits are consulted only in the last (level-1) entry.
- R5: A walk with no fault returns fault = 0, code = 0 and address = {leaf base, request address bits 11:0}, with bits 63:52 zero.
- R6: If request address bits 63:48 are not all zero, the walk returns code 1 and issues no memory read.
- R7: A root entry with bit 0 clear returns code 2 after one read. A context entry with bit 0 clear returns code 3 after two reads.
- R8: A page-table entry with bit 0 clear at any of the four levels returns code 4, and no later level is read.
- R9: A read request whose leaf entry has bit 1 clear returns code 5. A write request whose leaf entry has bit 2 clear returns code 6. On any fault the returned address is zero and fault = 1.
- R10: A memory read is a one-cycle pulse on memReqValid, and no new read is issued until the response for the previous one has arrived.
- R11: reqReady drops in the cycle after a request is accepted and stays low until the result is given. rspValid is a one-cycle pulse, and reqReady is high again in the next cycle.
- R12: After reset, reqReady = 1, memReqValid = 0 and rspValid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqRid | input | 16 | Requester ID (bus, device, function) |
| reqAddr | input | 64 | DMA address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| rootBase | input | 40 | Frame number of the root table |
| memReqValid | output | 1 | Memory read issue pulse |
| memReqAddr | output | 64 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Entry read from memory |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Walk ended in a fault |
| rspCode | output | 3 | Fault code (0 when no fault) |
| rspAddr | output | 64 | Translated host physical address |

## Verification
The assertions assume that the memory port returns exactly one memRspValid pulse for each memReqValid pulse, and never one when no read is pending. They also assume that the request fields are only meaningful in the cycle the request is accepted. The bench memory model keeps to these rules: it holds a single pending read and answers it after a latency of one to three cycles. The request driver raises reqValid for exactly one accepting edge. The sweep covers every fault kind, a missing entry at each of the four levels, and index values at both ends of their range.

// File: rtl/walker_pkg.sv
package walker_pkg;
  // Fixed four-level tree; stage order is the read order of a walk.
  localparam int LEVELS = 4;

  typedef enum logic [2:0] {
    STG_ROOT = 3'd0,
    STG_CTX  = 3'd1,
    STG_L4   = 3'd2,
    STG_L3   = 3'd3,
    STG_L2   = 3'd4,
    STG_L1   = 3'd5
  } stage_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_HIGHBITS = 3'd1,
    FLT_ROOT_NP  = 3'd2,
    FLT_CTX_NP   = 3'd3,
    FLT_PTE_NP   = 3'd4,
    FLT_NO_READ  = 3'd5,
    FLT_NO_WRITE = 3'd6
  } fault_e;

  typedef struct packed {
    logic   loadReq;    // capture request fields and root base
    logic   loadBase;   // take next base from the returned entry
    logic   setResult;  // latch the outcome of the walk
    fault_e code;       // outcome code used with setResult
    stage_e stage;      // selects the table index
  } dpStrobe_t;
endpackage

// File: rtl/walker_dpath.sv
module walker_dpath
  import walker_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FRAME_W = 40,
  parameter int IDX_W   = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [15:0]       reqRid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [FRAME_W-1:0] rootBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              highBad,
  output logic              isWrite,
  output logic              entPresent,
  output logic              entRead,
  output logic              entWrite,
  output logic              resFault,
  output logic [2:0]        resCode,
  output logic [ADDR_W-1:0] resAddr
);
  localparam int PAGE_SHIFT = IDX_W + 3;
  localparam int VA_W       = PAGE_SHIFT + LEVELS * IDX_W;
  localparam int PAD_W      = ADDR_W - FRAME_W - PAGE_SHIFT;
  localparam int SEL_W      = $clog2(LEVELS);

  logic [15:0]        ridQ;
  logic [ADDR_W-1:0]  addrQ;
  logic               writeQ;
  logic [FRAME_W-1:0] curBase;
  logic [IDX_W-1:0]   lvlIdx [LEVELS];
  logic [IDX_W-1:0]   tblIdx;
  logic [FRAME_W-1:0] entBase;
  logic [2:0]         lvlSel;
  logic               entryUnused;

  // Level index fields: entry 0 is the top level.
  for (genvar gi = 0; gi < LEVELS; gi++) begin : g_idx
    assign lvlIdx[gi] = addrQ[PAGE_SHIFT + IDX_W*(LEVELS-1-gi) +: IDX_W];
  end

  assign entBase     = memRspData[PAGE_SHIFT +: FRAME_W];
  assign entPresent  = memRspData[0];
  assign entRead     = memRspData[1];
  assign entWrite    = memRspData[2];
  assign entryUnused = ^{memRspData[ADDR_W-1:FRAME_W+PAGE_SHIFT], memRspData[PAGE_SHIFT-1:3]};
  assign highBad     = |addrQ[ADDR_W-1:VA_W];
  assign isWrite     = writeQ;
  assign lvlSel      = 3'(strb.stage) - 3'(STG_L4);

  always_comb begin
    unique case (strb.stage)
      STG_ROOT: tblIdx = IDX_W'(ridQ[15:8]);
      STG_CTX:  tblIdx = IDX_W'(ridQ[7:0]);
      default:  tblIdx = lvlIdx[lvlSel[SEL_W-1:0]];
    endcase
  end

  assign memReqAddr = {{PAD_W{1'b0}}, curBase, tblIdx, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ridQ    <= '0;
      addrQ   <= '0;
      writeQ  <= 1'b0;
      curBase <= '0;
    end else begin
      if (strb.loadReq) begin
        ridQ    <= reqRid;
        addrQ   <= reqAddr;
        writeQ  <= reqWrite;
        curBase <= rootBase;
      end else if (strb.loadBase) begin
        curBase <= entBase;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resFault <= 1'b0;
      resCode  <= '0;
      resAddr  <= '0;
    end else if (strb.setResult) begin
      resFault <= (strb.code != FLT_NONE);
      resCode  <= strb.code;
      resAddr  <= (strb.code == FLT_NONE)
                  ? {{PAD_W{1'b0}}, entBase, addrQ[PAGE_SHIFT-1:0]} : '0;
    end
  end

  // R6: an out-of-range address must end as code 1
  p_high_fault_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setResult && highBad) |=> (resFault && resCode == 3'd1));

  // R5: a clean walk keeps the page offset untouched
  p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setResult && strb.code == FLT_NONE) |=>
      (resAddr[PAGE_SHIFT-1:0] == $past(addrQ[PAGE_SHIFT-1:0]) && !resFault));
endmodule

// File: rtl/walker_ctrl.sv
module walker_ctrl
  import walker_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  output logic      memReqValid,
  input  logic      memRspValid,
  output logic      rspValid,
  input  logic      highBad,
  input  logic      isWrite,
  input  logic      entPresent,
  input  logic      entRead,
  input  logic      entWrite,
  output dpStrobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e stateQ, stateD;
  stage_e stageQ, stageD;

  always_comb begin
    stateD         = stateQ;
    stageD         = stageQ;
    strb           = '0;
    strb.stage     = stageQ;
    strb.code      = FLT_NONE;
    reqReady       = 1'b0;
    memReqValid    = 1'b0;
    rspValid       = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.loadReq = 1'b1;
          stageD       = STG_ROOT;
          stateD       = S_ISSUE;
        end
      end
      S_ISSUE: begin
        if (stageQ == STG_ROOT && highBad) begin
          strb.setResult = 1'b1;
          strb.code      = FLT_HIGHBITS;
          stateD         = S_DONE;
        end else begin
          memReqValid = 1'b1;
          stateD      = S_WAIT;
        end
      end
      S_WAIT: begin
        if (memRspValid) begin
          if (!entPresent) begin
            strb.setResult = 1'b1;
            strb.code      = (stageQ == STG_ROOT) ? FLT_ROOT_NP :
                             (stageQ == STG_CTX)  ? FLT_CTX_NP  : FLT_PTE_NP;
            stateD         = S_DONE;
          end else if (stageQ == STG_L1) begin
            strb.setResult = 1'b1;
            if (isWrite) strb.code = entWrite ? FLT_NONE : FLT_NO_WRITE;
            else         strb.code = entRead  ? FLT_NONE : FLT_NO_READ;
            stateD         = S_DONE;
          end else begin
            strb.loadBase = 1'b1;
            stageD        = stage_e'(3'(stageQ) + 3'd1);
            stateD        = S_ISSUE;
          end
        end
      end
      default: begin
        rspValid = 1'b1;
        stateD   = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stageQ <= STG_ROOT;
    end else begin
      stateQ <= stateD;
      stageQ <= stageD;
    end
  end

  // R10: a read is a single-cycle pulse
  p_single_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R11: acceptance closes the input until the result
  p_ready_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R11: one-cycle result, then ready again
  p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  // R10: nothing issued while a response is pending and not yet seen
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memRspValid) |=> !memReqValid);
endmodule

// File: rtl/dma_remap_walker.sv
module dma_remap_walker
  import walker_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int FRAME_W = 40,
  parameter int IDX_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [15:0]        reqRid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic [FRAME_W-1:0] rootBase,
  output logic               memReqValid,
  output logic [ADDR_W-1:0]  memReqAddr,
  input  logic               memRspValid,
  input  logic [ADDR_W-1:0]  memRspData,
  output logic               rspValid,
  output logic               rspFault,
  output logic [2:0]         rspCode,
  output logic [ADDR_W-1:0]  rspAddr
);
  dpStrobe_t strb;
  logic highBad, isWrite, entPresent, entRead, entWrite;

  walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .memRspValid(memRspValid),
    .rspValid   (rspValid),
    .highBad    (highBad),
    .isWrite    (isWrite),
    .entPresent (entPresent),
    .entRead    (entRead),
    .entWrite   (entWrite),
    .strb       (strb)
  );

  walker_dpath #(
    .ADDR_W (ADDR_W),
    .FRAME_W(FRAME_W),
    .IDX_W  (IDX_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqRid     (reqRid),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .rootBase   (rootBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .highBad    (highBad),
    .isWrite    (isWrite),
    .entPresent (entPresent),
    .entRead    (entRead),
    .entWrite   (entWrite),
    .resFault   (rspFault),
    .resCode    (rspCode),
    .resAddr    (rspAddr)
  );

  // R6: a high-bit fault never touches memory
  p_no_read_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspCode == 3'd1) |-> !memReqValid);
endmodule

// File: tb/dma_remap_walker_bench.sv
module dma_remap_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqRid = '0;
  logic [63:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [39:0] rootBase = '0;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid;
  logic        rspFault;
  logic [2:0]  rspCode;
  logic [63:0] rspAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int lat    = 1;
  int pendCnt = 0;
  logic [63:0] pendAddr = '0;
  logic [63:0] readLog [16];
  int readCnt = 0;
  logic [63:0] mem [logic [63:0]];

  always #4 clk = ~clk;

  dma_remap_walker u_dma_remap_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRid(reqRid), .reqAddr(reqAddr), .reqWrite(reqWrite), .rootBase(rootBase),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspFault(rspFault), .rspCode(rspCode), .rspAddr(rspAddr)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Memory model: one pending read, answered after lat cycles.
  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = mem.exists(pendAddr) ? mem[pendAddr] : 64'h0;
      end
    end
    if (memReqValid && rstN) begin
      if (readCnt < 16) readLog[readCnt] = memReqAddr;
      readCnt++;
      pendAddr = memReqAddr;
      pendCnt  = lat;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  function automatic logic [63:0] entAddr(input logic [39:0] frame, input int idx);
    return {12'h0, frame, 12'h0} + 64'(idx) * 64'd8;
  endfunction

  // R4: bits outside 51:12 and 2:0 are filled with junk that must be ignored
  function automatic logic [63:0] mkEnt(input logic [39:0] frame, input logic p, input logic r, input logic w);
    return 64'h4000_0000_0000_00F0 | {12'h0, frame, 12'h0} | {61'h0, w, r, p};
  endfunction

  task automatic runTrial(input int t);
    int kind, npLevel, bus, devfn, off, expReads, expCode, waitCnt;
    int idx [4];
    logic [39:0] b0, tb, leaf, rb;
    logic [15:0] high;
    logic isWr, leafR, leafW;
    logic [63:0] expA [6];
    logic [63:0] expAddr;

    kind    = t % 8;
    npLevel = (t / 8) % 4;
    lat     = 1 + t % 3;
    bus     = (t * 53) % 256;
    devfn   = (t * 29 + 7) % 256;
    idx[0]  = (t * 37) % 512;
    idx[1]  = (t * 101 + 3) % 512;
    idx[2]  = (t * 7 + 500) % 512;
    idx[3]  = 511 - (t % 512);
    off     = (t * 291) % 4096;
    high    = (kind == 2) ? 16'(1 << (t % 16)) : 16'h0;
    isWr    = (kind == 1 || kind == 7);
    rb      = 40'h1 + 40'(t);
    b0      = 40'h200 + 40'(bus);
    tb      = 40'h1000 + 40'(t * 8);
    leaf    = 40'hABC00 + 40'(t);

    case (kind)
      0, 7:    begin leafR = 1'b1; leafW = 1'b0; end
      1, 6:    begin leafR = 1'b0; leafW = 1'b1; end
      default: begin leafR = 1'b1; leafW = 1'b1; end
    endcase

    mem.delete();
    expA[0] = entAddr(rb, bus);
    expA[1] = entAddr(b0, devfn);
    mem[expA[0]] = mkEnt(b0, kind != 3, 1'b0, 1'b0);
    mem[expA[1]] = mkEnt(tb, kind != 4, 1'b0, 1'b0);
    for (int lv = 0; lv < 4; lv++) begin
      expA[2+lv] = entAddr(tb + 40'(lv), idx[lv]);
      mem[expA[2+lv]] = mkEnt((lv < 3) ? tb + 40'(lv + 1) : leaf,
                              !(kind == 5 && lv == npLevel),
                              (lv == 3) ? leafR : 1'b0,
                              (lv == 3) ? leafW : 1'b0);
    end

    case (kind)
      2: begin expCode = 1; expReads = 0; end
      3: begin expCode = 2; expReads = 1; end
      4: begin expCode = 3; expReads = 2; end
      5: begin expCode = 4; expReads = 3 + npLevel; end
      6: begin expCode = 5; expReads = 6; end
      7: begin expCode = 6; expReads = 6; end
      default: begin expCode = 0; expReads = 6; end
    endcase
    expAddr = (expCode == 0) ? {12'h0, leaf, 12'(off)} : 64'h0;

    readCnt = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R11 ready idle", 64'(reqReady), 64'd1);
    reqValid = 1'b1;
    reqRid   = {8'(bus), 8'(devfn)};
    reqAddr  = {high, 9'(idx[0]), 9'(idx[1]), 9'(idx[2]), 9'(idx[3]), 12'(off)};
    reqWrite = isWr;
    rootBase = rb;
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = '1;
    check(reqReady == 1'b0, "R11 ready low in walk", 64'(reqReady), 64'd0);
    waitCnt = 0;
    while (!rspValid && waitCnt < 200) begin
      @(negedge clk);
      waitCnt++;
    end
    check(rspValid == 1'b1, "R11 result arrives", 64'(rspValid), 64'd1);
    check(reqReady == 1'b0, "R11 ready low at result", 64'(reqReady), 64'd0);
    if (expCode == 0)
      check(rspAddr == expAddr && !rspFault && rspCode == 3'd0, "R5 translated address", rspAddr, expAddr);
    else if (expCode == 1)
      check(rspCode == 3'd1 && rspFault, "R6 high bits fault code", 64'(rspCode), 64'd1);
    else if (expCode <= 3)
      check(rspCode == 3'(expCode) && rspFault, "R7 assignment fault code", 64'(rspCode), 64'(expCode));
    else if (expCode == 4)
      check(rspCode == 3'd4 && rspFault, "R8 missing table entry code", 64'(rspCode), 64'd4);
    else
      check(rspCode == 3'(expCode) && rspFault, "R9 permission fault code", 64'(rspCode), 64'(expCode));
    if (expCode != 0)
      check(rspAddr == 64'h0, "R9 fault address zero", rspAddr, 64'h0);
    check(readCnt == expReads, (kind == 2) ? "R6 no reads" : "R8 read count", 64'(readCnt), 64'(expReads));
    for (int k = 0; k < expReads && k < readCnt; k++) begin
      check(readLog[k] == expA[k],
            (k == 0) ? "R1 root entry address" : (k == 1) ? "R2 context entry address" : "R3 level entry address",
            readLog[k], expA[k]);
    end
    @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R11 pulse then ready", {62'h0, rspValid, reqReady}, 64'd1);
  endtask

  // R10: a read never overlaps a pending one (bench-side observation)
  always @(negedge clk) begin
    if (rstN && memReqValid && pendCnt > 0 && !memRspValid) begin
      checks++;
      fails++;
      $display("FAIL R10 overlapping read actual=%h expected=none", memReqAddr);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R12 reset ready", 64'(reqReady), 64'd1);
    check(memReqValid == 1'b0, "R12 reset no read", 64'(memReqValid), 64'd0);
    check(rspValid == 1'b0, "R12 reset no result", 64'(rspValid), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    for (int t = 0; t < 96; t++) runTrial(t);
    finishRun();
  end
endmodule